// File: doc/BRIEF.md
# Collision Jam and Retry Controller

This block governs a half-duplex Ethernet transmitter once the medium reports a collision. It qualifies the asynchronous collision input with a run-length filter and decides when the jam begins. If the preamble and start delimiter are still going out, the jam waits for them to finish. If frame data is going out and the slot boundary has not yet been reached, the data is cut off and the jam starts at once. After each jam, the block either asks the backoff logic for a new slot, or ends the frame and reports the outcome.

The block keeps a count of the collisions seen in the current frame. From that count it chooses one of three statistics strobes: one retry, several retries, or too many collisions. When the attempt limit is reached, or when retries are disabled, it either discards the buffered frame or starts it again as a new frame. The serialiser is expected to send zeros for as long as `jamReq` is high. It is also expected to report its bit position. Backoff timing and data serialisation belong to neighbouring blocks. One clock cycle is one bit time.

Top module: `collision_retry_ctrl`

## Requirements
- R1: A collision is recognised only after `colIn` has been sampled high on FILT_CYC consecutive clock edges (default 3). A shorter assertion has no effect on `jamReq` or on the attempt count.
- R2: A collision recognised while `preDone` is 0 starts no jam until `preDone` is 1. The jam then begins one cycle later and `abortData` stays 0.
- R3: A collision recognised while `preDone` is 1 and `bitCnt` is below SLOT_BITS (default 512) starts the jam on the next clock edge. `abortData` pulses high for that one cycle.
- R4: `jamReq` stays high for exactly JAM_BITS (default 32) consecutive cycles per recognised collision.
- R5: In the cycle after a jam ends, `backoffReq` pulses if retries are enabled and fewer than MAX_ATT (default 16) collisions have hit the frame.
- R6: A `txDone` pulse drives the outcome strobes one cycle later. After exactly one collision in the frame, `incOne` pulses. After two or more, `incMulti` pulses. After none, no strobe pulses. The collision count then returns to zero.
- R7: If the jam that ends a frame's MAX_ATT-th collision finishes, `incExcess` pulses instead of `backoffReq`. If `restartEn` is 0, `flushFrame` pulses as well. If `restartEn` is 1, `restartFrame` pulses and the collision count is cleared.
- R8: With `retryDis` at 1, the first jam of a frame ends with `incExcess` and `flushFrame` and without `backoffReq`.
- R9: A collision recognised while `preDone` is 1 and `bitCnt` is at least SLOT_BITS is late. It produces no jam, no abort and no backoff, and it is not counted.
- R10: A `frameStart` pulse clears the collision count.
- R11: Out of reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| colIn | input | 1 | Collision input from the PHY, unqualified |
| txActive | input | 1 | An attempt is on the wire |
| preDone | input | 1 | Preamble and start delimiter are complete |
| bitCnt | input | POS_W | Frame bits sent after the delimiter, saturating |
| frameStart | input | 1 | Pulse: a new frame begins |
| txDone | input | 1 | Pulse: the current attempt finished without collision |
| retryDis | input | 1 | Abandon the frame on its first collision |
| restartEn | input | 1 | On too many collisions, resend the frame instead of discarding it |
| jamReq | output | 1 | Send jam (zeros) this bit time |
| abortData | output | 1 | Pulse: frame data was cut off for a jam |
| backoffReq | output | 1 | Pulse: reschedule via backoff |
| flushFrame | output | 1 | Pulse: discard the buffered frame |
| restartFrame | output | 1 | Pulse: resend the buffered frame as new |
| incOne | output | 1 | Pulse: one-retry statistic |
| incMulti | output | 1 | Pulse: multiple-retry statistic |
| incExcess | output | 1 | Pulse: excessive-collision statistic |

## Verification
The collision input is driven high on a falling edge. The filter recognises it on the third rising edge after that, and `jamReq` is sampled at the falling edge that follows. In the held case, it is sampled one cycle after `preDone` rises. The bench then counts how many falling-edge samples `jamReq` stays high. The backoff, flush, restart and statistics pulses are read at the first falling edge on which `jamReq` is low, and the `txDone` strobes are read at the falling edge after the pulse. For every collision count from zero to sixteen, the expected strobe is derived from the count alone.

// File: rtl/colr_pkg.sv
package colr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_JAM  = 2'd2
  } colState_t;

  typedef struct packed {
    logic jamLoad;
    logic jamStep;
    logic attInc;
    logic attClr;
  } colStrobe_t;
endpackage

// File: rtl/colr_datapath.sv
module colr_datapath
  import colr_pkg::*;
#(
  parameter int FILT_CYC = 3,
  parameter int JAM_BITS = 32,
  parameter int MAX_ATT  = 16,
  localparam int FILT_W  = $clog2(FILT_CYC + 1),
  localparam int JAM_W   = $clog2(JAM_BITS),
  localparam int ATT_W   = $clog2(MAX_ATT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             colIn,
  input  colStrobe_t       strobe,
  output logic             colEvt,
  output logic             jamLast,
  output logic [ATT_W-1:0] attCnt
);
  logic [FILT_W-1:0] colRun;
  logic [JAM_W-1:0]  jamCnt;

  // consecutive-high run length of the collision input
  always_ff @(posedge clk) begin
    if (!rstN)                             colRun <= '0;
    else if (!colIn)                       colRun <= '0;
    else if (colRun != FILT_W'(FILT_CYC))  colRun <= colRun + 1'b1;
  end

  // single event on the qualifying sample
  assign colEvt = colIn && (colRun == FILT_W'(FILT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN)               jamCnt <= '0;
    else if (strobe.jamLoad) jamCnt <= '0;
    else if (strobe.jamStep) jamCnt <= jamCnt + 1'b1;
  end

  assign jamLast = (jamCnt == JAM_W'(JAM_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rstN)                                         attCnt <= '0;
    else if (strobe.attClr)                            attCnt <= '0;
    else if (strobe.attInc && attCnt != ATT_W'(MAX_ATT)) attCnt <= attCnt + 1'b1;
  end
endmodule

// File: rtl/colr_ctrl.sv
module colr_ctrl
  import colr_pkg::*;
#(
  parameter int POS_W     = 12,
  parameter int SLOT_BITS = 512,
  parameter int MAX_ATT   = 16,
  localparam int ATT_W    = $clog2(MAX_ATT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             colEvt,
  input  logic             jamLast,
  input  logic [ATT_W-1:0] attCnt,
  input  logic             txActive,
  input  logic             preDone,
  input  logic [POS_W-1:0] bitCnt,
  input  logic             frameStart,
  input  logic             txDone,
  input  logic             retryDis,
  input  logic             restartEn,
  output colStrobe_t       strobe,
  output logic             jamReq,
  output logic             abortData,
  output logic             backoffReq,
  output logic             flushFrame,
  output logic             restartFrame,
  output logic             incOne,
  output logic             incMulti,
  output logic             incExcess
);
  colState_t state;
  logic lateCol, liveCol, lastAtt, endFrame;

  assign lateCol  = preDone && (bitCnt >= POS_W'(SLOT_BITS));
  assign liveCol  = txActive && colEvt && !lateCol;
  assign lastAtt  = (attCnt == ATT_W'(MAX_ATT));
  assign endFrame = retryDis || lastAtt;
  assign jamReq   = (state == ST_JAM);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (liveCol) begin
          strobe.attInc  = 1'b1;
          strobe.jamLoad = preDone;
        end else if (txDone || frameStart) begin
          strobe.attClr = 1'b1;
        end
      end
      ST_HOLD: strobe.jamLoad = preDone;
      ST_JAM: begin
        strobe.jamStep = 1'b1;
        strobe.attClr  = jamLast && endFrame;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      abortData    <= 1'b0;
      backoffReq   <= 1'b0;
      flushFrame   <= 1'b0;
      restartFrame <= 1'b0;
      incOne       <= 1'b0;
      incMulti     <= 1'b0;
      incExcess    <= 1'b0;
    end else begin
      abortData    <= 1'b0;
      backoffReq   <= 1'b0;
      flushFrame   <= 1'b0;
      restartFrame <= 1'b0;
      incOne       <= 1'b0;
      incMulti     <= 1'b0;
      incExcess    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (liveCol) begin
            state     <= preDone ? ST_JAM : ST_HOLD;
            abortData <= preDone;
          end else if (txDone) begin
            incOne   <= (attCnt == ATT_W'(1));
            incMulti <= (attCnt > ATT_W'(1));
          end
        end
        ST_HOLD: if (preDone) state <= ST_JAM;
        ST_JAM: begin
          if (jamLast) begin
            state <= ST_IDLE;
            if (endFrame) begin
              incExcess    <= 1'b1;
              restartFrame <= !retryDis && restartEn;
              flushFrame   <= retryDis || !restartEn;
            end else begin
              backoffReq <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/collision_retry_ctrl.sv
module collision_retry_ctrl
  import colr_pkg::*;
#(
  parameter int POS_W     = 12,
  parameter int SLOT_BITS = 512,
  parameter int FILT_CYC  = 3,
  parameter int JAM_BITS  = 32,
  parameter int MAX_ATT   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             colIn,
  input  logic             txActive,
  input  logic             preDone,
  input  logic [POS_W-1:0] bitCnt,
  input  logic             frameStart,
  input  logic             txDone,
  input  logic             retryDis,
  input  logic             restartEn,
  output logic             jamReq,
  output logic             abortData,
  output logic             backoffReq,
  output logic             flushFrame,
  output logic             restartFrame,
  output logic             incOne,
  output logic             incMulti,
  output logic             incExcess
);
  localparam int ATT_W = $clog2(MAX_ATT + 1);

  colStrobe_t       strobe;
  logic             colEvt, jamLast;
  logic [ATT_W-1:0] attCnt;

  colr_datapath #(.FILT_CYC(FILT_CYC), .JAM_BITS(JAM_BITS), .MAX_ATT(MAX_ATT)) uDp (
    .clk(clk), .rstN(rstN), .colIn(colIn), .strobe(strobe),
    .colEvt(colEvt), .jamLast(jamLast), .attCnt(attCnt)
  );

  colr_ctrl #(.POS_W(POS_W), .SLOT_BITS(SLOT_BITS), .MAX_ATT(MAX_ATT)) uCtl (
    .clk(clk), .rstN(rstN), .colEvt(colEvt), .jamLast(jamLast), .attCnt(attCnt),
    .txActive(txActive), .preDone(preDone), .bitCnt(bitCnt),
    .frameStart(frameStart), .txDone(txDone), .retryDis(retryDis),
    .restartEn(restartEn), .strobe(strobe), .jamReq(jamReq),
    .abortData(abortData), .backoffReq(backoffReq), .flushFrame(flushFrame),
    .restartFrame(restartFrame), .incOne(incOne), .incMulti(incMulti),
    .incExcess(incExcess)
  );
endmodule

// File: rtl/collision_retry_chk.sv
module collision_retry_chk #(
  parameter int JAM_BITS = 32
) (
  input logic clk,
  input logic rstN,
  input logic jamReq,
  input logic abortData,
  input logic backoffReq,
  input logic flushFrame,
  input logic restartFrame,
  input logic incOne,
  input logic incMulti,
  input logic incExcess,
  input logic retryDis
);
  localparam int LEN_W = $clog2(JAM_BITS + 2);
  logic [LEN_W-1:0] jamLen;

  always_ff @(posedge clk) begin
    if (!rstN)       jamLen <= '0;
    else if (jamReq) jamLen <= jamLen + 1'b1;
    else             jamLen <= '0;
  end

  // R4: every jam lasts exactly JAM_BITS cycles
  a_r4_jam_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(jamReq) |-> jamLen == LEN_W'(JAM_BITS));

  // R3: an abort coincides with the first jam cycle
  a_r3_abort_in_jam: assert property (@(posedge clk) disable iff (!rstN)
    abortData |-> jamReq && !$past(jamReq));

  // R5: backoff only right after a jam
  a_r5_backoff_after_jam: assert property (@(posedge clk) disable iff (!rstN)
    backoffReq |-> !jamReq && $past(jamReq));

  // R6: at most one statistics strobe per cycle
  a_r6_one_stat: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({incOne, incMulti, incExcess}));

  // R7: an excessive outcome always discards or resends, never both
  a_r7_excess_action: assert property (@(posedge clk) disable iff (!rstN)
    incExcess |-> (flushFrame ^ restartFrame) && !backoffReq);

  // R8: no rescheduling while retries are disabled
  a_r8_no_backoff_disabled: assert property (@(posedge clk) disable iff (!rstN)
    backoffReq |-> !$past(retryDis));
endmodule

bind collision_retry_ctrl collision_retry_chk #(.JAM_BITS(JAM_BITS)) uChk (
  .clk(clk), .rstN(rstN), .jamReq(jamReq), .abortData(abortData),
  .backoffReq(backoffReq), .flushFrame(flushFrame), .restartFrame(restartFrame),
  .incOne(incOne), .incMulti(incMulti), .incExcess(incExcess), .retryDis(retryDis)
);

// File: tb/sim_collision_retry_ctrl.sv
`timescale 1ns/1ps
module sim_collision_retry_ctrl;
  localparam int JAM = 32;
  localparam int MAXA = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic colIn = 1'b0, txActive = 1'b0, preDone = 1'b0;
  logic [11:0] bitCnt = '0;
  logic frameStart = 1'b0, txDone = 1'b0, retryDis = 1'b0, restartEn = 1'b0;
  logic jamReq, abortData, backoffReq, flushFrame, restartFrame;
  logic incOne, incMulti, incExcess;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  collision_retry_ctrl u0 (
    .clk(clk), .rstN(rstN), .colIn(colIn), .txActive(txActive), .preDone(preDone),
    .bitCnt(bitCnt), .frameStart(frameStart), .txDone(txDone), .retryDis(retryDis),
    .restartEn(restartEn), .jamReq(jamReq), .abortData(abortData),
    .backoffReq(backoffReq), .flushFrame(flushFrame), .restartFrame(restartFrame),
    .incOne(incOne), .incMulti(incMulti), .incExcess(incExcess)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int outVec();
    return {backoffReq, flushFrame, restartFrame, incOne, incMulti, incExcess};
  endfunction

  // one recognised collision; returns at the first sample with jamReq low
  task automatic collide(input bit early);
    int len;
    if (early) preDone = 1'b0;
    colIn = 1'b1;
    repeat (3) @(negedge clk);
    colIn = 1'b0;
    if (early) begin
      chk("R2 jam held during preamble", jamReq, 0);
      preDone = 1'b1;
      @(negedge clk);
    end
    chk("R2/R3 jam started", jamReq, 1);
    chk(early ? "R2 no abort in preamble" : "R3 abort pulse", abortData, early ? 0 : 1);
    len = 1;
    for (int i = 0; i < JAM + 4; i++) begin
      @(negedge clk);
      if (!jamReq) break;
      len++;
    end
    chk("R4 jam length", len, JAM);
  endtask

  task automatic pulseDone();
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
  endtask

  task automatic newFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {jamReq, abortData, outVec()}, 0);
    rstN = 1'b1;
    txActive = 1'b1;
    preDone = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {jamReq, abortData, outVec()}, 0);

    // R5 R6: k collisions then success, k = 0..15
    for (int k = 0; k < MAXA; k++) begin
      newFrame();
      for (int c = 0; c < k; c++) begin
        bitCnt = 12'(511 - c * 30);
        collide(c % 3 == 0);
        chk("R5 backoff after jam", outVec(), 6'b100000);
        @(negedge clk);
      end
      pulseDone();
      chk("R6 success statistics", outVec(),
          (k == 1) ? 6'b000100 : (k >= 2) ? 6'b000010 : 6'b000000);
      @(negedge clk);
    end

    // R7: sixteen collisions, discard and resend variants
    for (int r = 0; r < 2; r++) begin
      restartEn = r[0];
      newFrame();
      for (int c = 0; c < MAXA; c++) begin
        bitCnt = 12'(c * 20);
        collide(1'b0);
        if (c < MAXA - 1) chk("R5 backoff before limit", outVec(), 6'b100000);
        else chk("R7 excessive outcome", outVec(), r ? 6'b001001 : 6'b010001);
        @(negedge clk);
      end
      if (r == 1) begin
        pulseDone();
        chk("R7 restart clears count", outVec(), 0);
        collide(1'b0);
        @(negedge clk);
        pulseDone();
        chk("R7 count after restart", outVec(), 6'b000100);
      end
      @(negedge clk);
    end
    restartEn = 1'b0;

    // R8: retries disabled
    for (int r = 0; r < 2; r++) begin
      retryDis = 1'b1;
      restartEn = r[0];
      newFrame();
      bitCnt = 12'd64;
      collide(1'b0);
      chk("R8 abandon on first collision", outVec(), 6'b010001);
      @(negedge clk);
    end
    retryDis = 1'b0;
    restartEn = 1'b0;

    // R9: late collision at boundary 512, one normal collision at 511
    newFrame();
    bitCnt = 12'd511;
    collide(1'b0);
    chk("R9 boundary 511 still normal", outVec(), 6'b100000);
    @(negedge clk);
    bitCnt = 12'd512;
    colIn = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (i == 4) colIn = 1'b0;
        seen |= {jamReq, abortData, backoffReq};
      end
      chk("R9 late collision ignored", seen, 0);
    end
    pulseDone();
    chk("R9 late collision not counted", outVec(), 6'b000100);
    @(negedge clk);

    // R1: short assertions filtered
    newFrame();
    bitCnt = 12'd100;
    for (int len = 1; len < 3; len++) begin
      int seen = 0;
      colIn = 1'b1;
      repeat (len) @(negedge clk);
      colIn = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        seen |= jamReq;
      end
      chk("R1 short pulse no jam", seen, 0);
    end
    pulseDone();
    chk("R1 short pulses not counted", outVec(), 0);
    @(negedge clk);

    // R10: frameStart clears count
    newFrame();
    collide(1'b1);
    @(negedge clk);
    collide(1'b0);
    @(negedge clk);
    newFrame();
    pulseDone();
    chk("R10 frame start clears count", outVec(), 0);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule